// File: doc/BRIEF.md
# Command FIFO Front End with Status Word

This block sits between a host register port and a drawing engine. Every host write to an ordinary address becomes a command entry, holding the address and the data, in a first-in first-out store. The entries leave one at a time, in arrival order, through a ready/valid handshake toward the engine. One reserved address is kept for the control and status word, and writes to that address never become commands.

The status word lets the host pace itself without full or empty flags. It reports how many entries are still free, and it never reports more space than there is. It also shows two busy indications, one for the rasteriser side and one for the framebuffer side. Two error bits are sticky: a read error signalled by the engine side, and an overflow recorded when the host writes while no entry is free. Writing ones to either error bit clears it.

Top module: `cmdq_frontend`

## Requirements
- R1: After synchronous reset the status word reads free count = DEPTH (16 by default), with bits 24, 25, 30 and 31 clear, and `cmd_valid` is low.
- R2: A write to any address other than `STATUS_ADDR` (default 0xFF) is stored as {address, data}. Stored entries appear on `cmd_addr`/`cmd_data` in arrival order. Each entry stays valid and unchanged until the cycle in which `cmd_ready` is high.
- R3: Status bits 11:0 give DEPTH minus the number of stored entries, updated in the cycle after a push or pop. The count never exceeds the true free space.
- R4: A command write that arrives while the free count is zero is discarded, leaving the stored entries unchanged, and sets status bit 31 (overflow), which stays set.
- R5: A one-cycle pulse on `rd_err_evt` sets status bit 30 (read error), which stays set until cleared.
- R6: A write to `STATUS_ADDR` clears bit 30 if data bit 30 is one and bit 31 if data bit 31 is one. Zero data bits leave the flags as they are. Such a write never enters the store and does not change the free count.
- R7: Status bit 25 (rasteriser busy) is one while the store holds any entry or while `eng_rast_busy` is high, and zero otherwise.
- R8: Status bit 24 (framebuffer busy) follows `eng_fb_busy`.
- R9: `host_rd_data` loads the status word at the clock edge where `host_rd_en` is high. It reflects every write accepted in earlier cycles and holds its value while `host_rd_en` is low. Bits 12-23 and 26-29 read zero.
- R10: If a read-error pulse and a clearing write to bit 30 occur in the same cycle, bit 30 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | 8 | Host write address |
| host_wr_data | input | 32 | Host write data |
| host_rd_en | input | 1 | Status read strobe |
| host_rd_data | output | 32 | Registered status word |
| rd_err_evt | input | 1 | Read-error event pulse from the engine side |
| eng_rast_busy | input | 1 | Downstream rasteriser busy |
| eng_fb_busy | input | 1 | Downstream framebuffer busy |
| cmd_valid | output | 1 | Command entry available |
| cmd_ready | input | 1 | Engine accepts the command entry |
| cmd_addr | output | 8 | Command register address |
| cmd_data | output | 32 | Command data |

## Verification
The bench fills the store completely and then writes two more commands. A design that stored those extra writes would release more entries than were queued, or in the wrong order. A design that missed them would leave the overflow bit clear. Status writes with zero data and with single flag bits show whether a design pushes status writes into the store or clears the wrong flag. A read-error pulse that coincides with its own clearing write catches a clear that takes priority over a new event. Busy bits are checked with an empty store, and `cmd_ready` is toggled while commands are pushed, so that a busy signal derived only from the engine, or an entry lost under back-pressure, shows up as a mismatch.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int CQ_ADDR_W         = 8;
    localparam int CQ_DATA_W         = 32;
    localparam int CQ_STAT_W         = 32;
    localparam int CQ_FREE_W         = 12;
    localparam int CQ_FB_BUSY_BIT    = 24;
    localparam int CQ_RAST_BUSY_BIT  = 25;
    localparam int CQ_RDERR_BIT      = 30;
    localparam int CQ_OVF_BIT        = 31;

    typedef struct packed {
        logic [CQ_ADDR_W-1:0] addr;
        logic [CQ_DATA_W-1:0] data;
    } cq_cmd_t;

    typedef struct packed {
        logic                 ovf;
        logic                 rderr;
        logic                 rast_busy;
        logic                 fb_busy;
        logic [CQ_FREE_W-1:0] free;
    } cq_stat_t;

    function automatic logic [CQ_STAT_W-1:0] cq_pack_status(cq_stat_t s);
        logic [CQ_STAT_W-1:0] w;
        w                   = '0;
        w[CQ_FREE_W-1:0]    = s.free;
        w[CQ_FB_BUSY_BIT]   = s.fb_busy;
        w[CQ_RAST_BUSY_BIT] = s.rast_busy;
        w[CQ_RDERR_BIT]     = s.rderr;
        w[CQ_OVF_BIT]       = s.ovf;
        return w;
    endfunction
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  cq_cmd_t                       push_item,
    input  logic                          pop,
    output cq_cmd_t                       head_item,
    output logic [$clog2(DEPTH+1)-1:0]    occupancy
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    cq_cmd_t          slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] advance(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_item;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= advance(wr_ptr);
            if (pop)  rd_ptr <= advance(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_item = slots[rd_ptr];
    assign occupancy = count;
endmodule

// File: rtl/cmdq_errflags.sv
module cmdq_errflags (
    input  logic clk,
    input  logic rst,
    input  logic set_ovf,
    input  logic set_rderr,
    input  logic clr_ovf,
    input  logic clr_rderr,
    output logic ovf,
    output logic rderr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf   <= 1'b0;
            rderr <= 1'b0;
        end else begin
            ovf   <= set_ovf   | (ovf   & ~clr_ovf);
            rderr <= set_rderr | (rderr & ~clr_rderr);
        end
    end
endmodule

// File: rtl/cmdq_frontend.sv
module cmdq_frontend
    import cmdq_pkg::*;
#(
    parameter int                   DEPTH       = 16,
    parameter logic [CQ_ADDR_W-1:0] STATUS_ADDR = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr_en,
    input  logic [CQ_ADDR_W-1:0] host_wr_addr,
    input  logic [CQ_DATA_W-1:0] host_wr_data,
    input  logic                 host_rd_en,
    output logic [CQ_STAT_W-1:0] host_rd_data,
    input  logic                 rd_err_evt,
    input  logic                 eng_rast_busy,
    input  logic                 eng_fb_busy,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [CQ_ADDR_W-1:0] cmd_addr,
    output logic [CQ_DATA_W-1:0] cmd_data
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic             wr_is_stat;
    logic             wr_is_cmd;
    logic             full;
    logic             push;
    logic             pop;
    logic             ovf_evt;
    logic [CNT_W-1:0] occupancy;
    cq_cmd_t          in_item;
    cq_cmd_t          head_item;
    logic             ovf_flag;
    logic             rderr_flag;
    cq_stat_t         stat;
    logic [CQ_STAT_W-1:0] status_word;

    assign wr_is_stat = host_wr_en && (host_wr_addr == STATUS_ADDR);
    assign wr_is_cmd  = host_wr_en && (host_wr_addr != STATUS_ADDR);
    assign full       = (occupancy == CNT_W'(DEPTH));
    assign push       = wr_is_cmd && !full;
    assign ovf_evt    = wr_is_cmd && full;
    assign pop        = cmd_valid && cmd_ready;
    assign in_item    = '{addr: host_wr_addr, data: host_wr_data};

    cmdq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_item (in_item),
        .pop       (pop),
        .head_item (head_item),
        .occupancy (occupancy)
    );

    cmdq_errflags u_err (
        .clk       (clk),
        .rst       (rst),
        .set_ovf   (ovf_evt),
        .set_rderr (rd_err_evt),
        .clr_ovf   (wr_is_stat && host_wr_data[CQ_OVF_BIT]),
        .clr_rderr (wr_is_stat && host_wr_data[CQ_RDERR_BIT]),
        .ovf       (ovf_flag),
        .rderr     (rderr_flag)
    );

    assign cmd_valid = (occupancy != '0);
    assign cmd_addr  = head_item.addr;
    assign cmd_data  = head_item.data;

    always_comb begin
        stat.free      = CQ_FREE_W'(DEPTH) - CQ_FREE_W'(occupancy);
        stat.fb_busy   = eng_fb_busy;
        stat.rast_busy = cmd_valid || eng_rast_busy;
        stat.rderr     = rderr_flag;
        stat.ovf       = ovf_flag;
        status_word    = cq_pack_status(stat);
    end

    always_ff @(posedge clk) begin
        if (rst)             host_rd_data <= '0;
        else if (host_rd_en) host_rd_data <= status_word;
    end
endmodule

// File: rtl/cmdq_frontend_chk.sv
module cmdq_frontend_chk
    import cmdq_pkg::*;
#(
    parameter int                   DEPTH       = 16,
    parameter logic [CQ_ADDR_W-1:0] STATUS_ADDR = 8'hFF
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 host_wr_en,
    input logic [CQ_ADDR_W-1:0] host_wr_addr,
    input logic [CQ_DATA_W-1:0] host_wr_data,
    input logic                 host_rd_en,
    input logic [CQ_STAT_W-1:0] host_rd_data,
    input logic                 rd_err_evt,
    input logic                 eng_fb_busy,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [CQ_ADDR_W-1:0] cmd_addr,
    input logic [CQ_DATA_W-1:0] cmd_data,
    input logic [CQ_STAT_W-1:0] status_word
);
    logic [CQ_FREE_W-1:0] free_f;
    logic                 stat_wr;
    assign free_f  = status_word[CQ_FREE_W-1:0];
    assign stat_wr = host_wr_en && (host_wr_addr == STATUS_ADDR);

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (free_f == CQ_FREE_W'(DEPTH)) && !cmd_valid);

    // R2
    a_r2_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_data));

    // R3
    a_r3_free_bound: assert property (@(posedge clk) disable iff (rst)
        (free_f <= CQ_FREE_W'(DEPTH)) && (cmd_valid -> (free_f < CQ_FREE_W'(DEPTH))));

    // R4
    a_r4_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && (host_wr_addr != STATUS_ADDR) && (free_f == '0))
        |=> status_word[CQ_OVF_BIT]);

    // R5
    a_r5_rderr_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_word[CQ_RDERR_BIT] && !(stat_wr && host_wr_data[CQ_RDERR_BIT]))
        |=> status_word[CQ_RDERR_BIT]);

    // R10
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        rd_err_evt |=> status_word[CQ_RDERR_BIT]);

    // R7
    a_r7_rast_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> status_word[CQ_RAST_BUSY_BIT]);

    // R8
    a_r8_fb_busy: assert property (@(posedge clk) disable iff (rst)
        status_word[CQ_FB_BUSY_BIT] == eng_fb_busy);

    // R9
    a_r9_read_hold: assert property (@(posedge clk) disable iff (rst)
        !host_rd_en |=> $stable(host_rd_data));
endmodule

bind cmdq_frontend cmdq_frontend_chk #(.DEPTH(DEPTH), .STATUS_ADDR(STATUS_ADDR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .host_wr_data (host_wr_data),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .rd_err_evt   (rd_err_evt),
    .eng_fb_busy  (eng_fb_busy),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data),
    .status_word  (status_word)
);

// File: tb/cmdq_frontend_test.sv
module cmdq_frontend_test;
    localparam int         DEPTH = 16;
    localparam logic [7:0] SADDR = 8'hFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_wr_addr = '0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        rd_err_evt = 1'b0;
    logic        eng_rast_busy = 1'b0;
    logic        eng_fb_busy = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_addr;
    logic [31:0] cmd_data;

    int checks = 0;
    int errors = 0;
    int pops   = 0;
    bit done   = 0;
    logic [39:0] sb [$];

    always #10 clk = ~clk;

    cmdq_frontend #(.DEPTH(DEPTH), .STATUS_ADDR(SADDR)) uut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .rd_err_evt(rd_err_evt), .eng_rast_busy(eng_rast_busy), .eng_fb_busy(eng_fb_busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    task automatic check(bit ok, string req, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic host_write(logic [7:0] a, logic [31:0] d, bit expect_store);
        host_wr_en   = 1'b1;
        host_wr_addr = a;
        host_wr_data = d;
        if (expect_store) sb.push_back({a, d});
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic read_status(output logic [31:0] v);
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        v = host_rd_data;
    endtask

    task automatic expect_status(logic [31:0] exp, string req);
        logic [31:0] v;
        read_status(v);
        check(v == exp, req, {8'h0, v}, {8'h0, exp});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // scoreboard monitor: samples just after the negedge where inputs settle
    always begin
        @(negedge clk);
        #1;
        if (!rst && cmd_valid && cmd_ready) begin
            pops++;
            if (sb.size() == 0) begin
                check(1'b0, "R4 extra entry left the store", {cmd_addr, cmd_data}, 40'h0);
            end else begin
                logic [39:0] e;
                e = sb.pop_front();
                check({cmd_addr, cmd_data} == e, "R2 order/content", {cmd_addr, cmd_data}, e);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(cmd_valid == 1'b0, "R1 cmd_valid", {39'h0, cmd_valid}, 40'h0);
        expect_status(32'h0000_0010, "R1 status after reset");

        // R3 R7 three stored entries, engine stalled
        host_write(8'h10, 32'hA000_0001, 1);
        host_write(8'h24, 32'hA000_0002, 1);
        host_write(8'h3C, 32'hA000_0003, 1);
        expect_status(32'h0200_000D, "R3 free count after three pushes");
        cmd_ready = 1'b1;
        idle(6);
        check(sb.size() == 0, "R2 all entries delivered", 40'(sb.size()), 40'h0);
        expect_status(32'h0000_0010, "R7 idle after drain");

        // R7 R8 downstream busy with empty store
        eng_rast_busy = 1'b1;
        @(negedge clk);
        expect_status(32'h0200_0010, "R7 engine busy, empty store");
        eng_rast_busy = 1'b0;
        eng_fb_busy   = 1'b1;
        @(negedge clk);
        expect_status(32'h0100_0010, "R8 framebuffer busy");
        eng_fb_busy = 1'b0;

        // R4 fill completely, then two extra writes
        cmd_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) host_write(8'(i), 32'hB000_0000 + i, 1);
        expect_status(32'h0200_0000, "R3 full reports zero free");
        host_write(8'h55, 32'hDEAD_0001, 0);
        host_write(8'h56, 32'hDEAD_0002, 0);
        expect_status(32'h8200_0000, "R4 overflow flag set");
        pops = 0;
        cmd_ready = 1'b1;
        idle(DEPTH + 4);
        check(pops == DEPTH, "R4 dropped writes not stored", 40'(pops), 40'(DEPTH));
        expect_status(32'h8000_0010, "R4 overflow sticky after drain");

        // R6 status writes
        cmd_ready = 1'b0;
        host_write(SADDR, 32'h0000_0000, 0);
        check(cmd_valid == 1'b0, "R6 status write not stored", {39'h0, cmd_valid}, 40'h0);
        expect_status(32'h8000_0010, "R6 zero write keeps flag and free count");
        host_write(SADDR, 32'h8000_0000, 0);
        expect_status(32'h0000_0010, "R6 overflow cleared");

        // R5 read error sticky
        rd_err_evt = 1'b1;
        @(negedge clk);
        rd_err_evt = 1'b0;
        expect_status(32'h4000_0010, "R5 read error set");
        idle(5);
        expect_status(32'h4000_0010, "R5 read error stays set");
        host_write(SADDR, 32'h8000_0000, 0);
        expect_status(32'h4000_0010, "R6 clearing bit31 leaves bit30");
        host_write(SADDR, 32'h4000_0000, 0);
        expect_status(32'h0000_0010, "R6 read error cleared");

        // R10 set wins over clear in the same cycle
        rd_err_evt = 1'b1;
        host_write(SADDR, 32'h4000_0000, 0);
        rd_err_evt = 1'b0;
        expect_status(32'h4000_0010, "R10 set wins");
        host_write(SADDR, 32'hC000_0000, 0);

        // R9 read port holds between reads
        read_status(snap);
        host_write(8'h77, 32'hC0DE_0007, 1);
        idle(2);
        check(host_rd_data == snap, "R9 hold without read", {8'h0, host_rd_data}, {8'h0, snap});
        expect_status(32'h0200_000F, "R9 read reflects earlier write");
        cmd_ready = 1'b1;
        idle(3);

        // R2 pushes under toggling back-pressure
        for (int i = 0; i < 6; i++) begin
            cmd_ready = i[0];
            host_write(8'h40 + 8'(i), 32'hE000_0000 + i, 1);
        end
        cmd_ready = 1'b1;
        idle(10);
        check(sb.size() == 0, "R2 stream under back-pressure drained", 40'(sb.size()), 40'h0);
        read_status(v);
        check(v == 32'h0000_0010, "R3 free count restored", {8'h0, v}, 40'h10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule